// File: doc/BRIEF.md
# Integer Compute Execute Unit

This block decodes and executes the integer arithmetic, logic, compare, shift and upper-immediate instructions of a 32-bit RISC-V base core. It takes one instruction word, the two source operand values already read from the register file, and the address of the instruction. In the same cycle it produces the value to write back, the destination register index, a write strobe and a flag that marks an encoding it does not accept. It has no state, so it can sit inside whatever pipeline stage the surrounding core chooses.

The standard opcode, funct3 and funct7 fields pick the operation directly. No separate ALU opcode input exists. Each instruction format applies its own immediate rule. The register-immediate form takes a sign-extended 12-bit value. The two upper-immediate forms place a 20-bit value above twelve zero bits. The first operand is either the rs1 value or the program counter. The second operand is either the rs2 value or the immediate.

Top module: `rvx_exec_unit`

## Requirements
- R1: Opcode field bits 6:0 choose the format: 0110011 is register-register, 0010011 is register-immediate, 0110111 loads an upper immediate, and 0010111 adds an upper immediate to the instruction address.
- R2: funct3 (bits 14:12) maps 000 to add, 001 to shift left, 010 to signed less-than, 011 to unsigned less-than, 100 to xor, 101 to shift right, 110 to or and 111 to and. The mapping is the same in both the register and the immediate forms.
- R3: In the register form, funct7 (bits 31:25) equal to 0100000 turns add into subtract and logical right shift into arithmetic right shift. A funct7 of 0000000 gives the plain operation.
- R4: The immediate-form operand is bits 31:20 sign-extended to 32 bits for every operation, including the and, or, xor and both compares. An addi with bit 30 set still adds.
- R5: Register shifts use only the low 5 bits of the rs2 value. Immediate shifts take the amount from bits 24:20. Logical right shifts fill with zeros, arithmetic right shifts fill with the sign bit, and a shift by zero returns the operand unchanged.
- R6: The signed compares treat both operands as two's complement. The unsigned compares treat them as unsigned, after the immediate has been sign-extended. The result is always 0 or 1.
- R7: The upper-immediate load returns bits 31:12 of the instruction in result bits 31:12, with bits 11:0 set to zero. The rs1 value is ignored.
- R8: The instruction-address form returns the program counter plus instruction bits 31:12 shifted left by 12.
- R9: Add, subtract, addi and the instruction-address add wrap modulo 2^32 and flag nothing.
- R10: The write strobe stays low whenever the destination index (bits 11:7) is zero, so addi x0, x0, 0 changes nothing.
- R11: An unknown opcode, a register-form funct7 other than the two listed, subtract/arithmetic funct7 on any other funct3, or wrong bits 31:25 on an immediate shift (0000000 for left and logical right, 0100000 for arithmetic right) raises the illegal flag. The write strobe is then low and the result is zero.
- R12: For every accepted instruction the destination index output equals bits 11:7, the illegal flag is low, and the write strobe is high when that index is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | First source operand value |
| rs2_val_i | input | 32 | Second source operand value |
| pc_i | input | 32 | Address of the instruction |
| result_o | output | 32 | Write-back value |
| rd_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write strobe for the destination |
| illegal_o | output | 1 | Encoding not accepted |

## Verification
The embedded assertions check several rules continuously, on whatever inputs are present. An illegal encoding never writes, and register zero is never written. An accepted instruction with a nonzero destination always writes. Compare results are only ever 0 or 1, a shift by zero is the identity, a subtraction undone by adding the operand back gives the minuend, and the upper-immediate load leaves the low twelve bits clear. Only the bench scenarios can show the rest, because each depends on one particular encoding: that each funct3 and funct7 combination selects the right operation, that immediates are sign-extended into the logical ops and the unsigned compare, that arithmetic and logical right shifts fill differently, that the instruction-address add and plain add wrap at 2^32, and that each class of bad encoding is caught.

// File: rtl/rvx_pkg.sv
package rvx_pkg;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_SLL  = 3'b001;
  localparam logic [2:0] F3_SLT  = 3'b010;
  localparam logic [2:0] F3_SLTU = 3'b011;
  localparam logic [2:0] F3_XOR  = 3'b100;
  localparam logic [2:0] F3_SR   = 3'b101;
  localparam logic [2:0] F3_OR   = 3'b110;
  localparam logic [2:0] F3_AND  = 3'b111;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
    OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND, OP_PASS_B
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT, SH_RIGHT_LOG, SH_RIGHT_ARI
  } shift_kind_e;

  function automatic alu_op_e op_from_f3(input logic [2:0] f3, input logic alt);
    alu_op_e op;
    case (f3)
      F3_ADD:  op = alt ? OP_SUB : OP_ADD;
      F3_SLL:  op = OP_SLL;
      F3_SLT:  op = OP_SLT;
      F3_SLTU: op = OP_SLTU;
      F3_XOR:  op = OP_XOR;
      F3_SR:   op = alt ? OP_SRA : OP_SRL;
      F3_OR:   op = OP_OR;
      default: op = OP_AND;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/rvx_decode.sv
module rvx_decode
  import rvx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  output alu_op_e         op_o,
  output logic            a_from_pc_o,
  output logic            b_from_imm_o,
  output logic [XLEN-1:0] imm_o,
  output logic [4:0]      rd_o,
  output logic            illegal_o
);

  logic [6:0]      opcode;
  logic [2:0]      f3;
  logic [6:0]      f7;
  logic [XLEN-1:0] imm_i_ext;
  logic [XLEN-1:0] imm_u_ext;

  assign opcode    = instr_i[6:0];
  assign f3        = instr_i[14:12];
  assign f7        = instr_i[31:25];
  assign rd_o      = instr_i[11:7];
  assign imm_i_ext = XLEN'($signed(instr_i[31:20]));
  assign imm_u_ext = XLEN'($signed({instr_i[31:12], 12'h000}));

  always_comb begin
    op_o         = OP_ADD;
    a_from_pc_o  = 1'b0;
    b_from_imm_o = 1'b0;
    imm_o        = '0;
    illegal_o    = 1'b0;
    case (opcode)
      OPC_REG: begin
        if (f7 == F7_BASE) begin
          op_o = op_from_f3(f3, 1'b0);
        end else if (f7 == F7_ALT && (f3 == F3_ADD || f3 == F3_SR)) begin
          op_o = op_from_f3(f3, 1'b1);
        end else begin
          illegal_o = 1'b1;
        end
      end
      OPC_IMM: begin
        b_from_imm_o = 1'b1;
        imm_o        = imm_i_ext;
        if (f3 == F3_SLL) begin
          op_o      = OP_SLL;
          illegal_o = (f7 != F7_BASE);
        end else if (f3 == F3_SR) begin
          op_o      = (f7 == F7_ALT) ? OP_SRA : OP_SRL;
          illegal_o = (f7 != F7_ALT) && (f7 != F7_BASE);
        end else begin
          op_o = op_from_f3(f3, 1'b0);
        end
      end
      OPC_LUI: begin
        op_o         = OP_PASS_B;
        b_from_imm_o = 1'b1;
        imm_o        = imm_u_ext;
      end
      OPC_AUIPC: begin
        op_o         = OP_ADD;
        a_from_pc_o  = 1'b1;
        b_from_imm_o = 1'b1;
        imm_o        = imm_u_ext;
      end
      default: illegal_o = 1'b1;
    endcase
  end

  always_comb begin
    if (opcode == OPC_IMM && f3 == F3_ADD) begin
      assert_addi_never_sub_R4: assert (op_o == OP_ADD)
        else $error("addi decoded as another operation");
    end
  end

endmodule

// File: rtl/rvx_shift.sv
module rvx_shift
  import rvx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]         a_i,
  input  logic [$clog2(XLEN)-1:0] shamt_i,
  input  shift_kind_e             kind_i,
  output logic [XLEN-1:0]         y_o
);

  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] a_rev;
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] res_rev;
  logic [XLEN-1:0] stage [SHW+1];
  logic            fill;

  for (genvar i = 0; i < XLEN; i++) begin : g_rev_in
    assign a_rev[i] = a_i[XLEN-1-i];
  end

  assign src      = (kind_i == SH_LEFT) ? a_rev : a_i;
  assign fill     = (kind_i == SH_RIGHT_ARI) & a_i[XLEN-1];
  assign stage[0] = src;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = shamt_i[s] ? {{STEP{fill}}, stage[s][XLEN-1:STEP]} : stage[s];
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_rev_out
    assign res_rev[i] = stage[SHW][XLEN-1-i];
  end

  assign y_o = (kind_i == SH_LEFT) ? res_rev : stage[SHW];

  always_comb begin
    if (shamt_i == '0) begin
      assert_zero_shift_identity_R5: assert (y_o == a_i)
        else $error("shift by zero altered operand");
    end
  end

endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
  import rvx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);

  localparam int SHW = $clog2(XLEN);

  shift_kind_e     sh_kind;
  logic [XLEN-1:0] sh_y;
  logic            lt_s;
  logic            lt_u;

  always_comb begin
    case (op_i)
      OP_SRL:  sh_kind = SH_RIGHT_LOG;
      OP_SRA:  sh_kind = SH_RIGHT_ARI;
      default: sh_kind = SH_LEFT;
    endcase
  end

  rvx_shift #(.XLEN(XLEN)) u_shift (
    .a_i     (a_i),
    .shamt_i (b_i[SHW-1:0]),
    .kind_i  (sh_kind),
    .y_o     (sh_y)
  );

  assign lt_s = $signed(a_i) < $signed(b_i);
  assign lt_u = a_i < b_i;

  always_comb begin
    case (op_i)
      OP_ADD:    y_o = a_i + b_i;
      OP_SUB:    y_o = a_i - b_i;
      OP_SLL,
      OP_SRL,
      OP_SRA:    y_o = sh_y;
      OP_SLT:    y_o = XLEN'(lt_s);
      OP_SLTU:   y_o = XLEN'(lt_u);
      OP_XOR:    y_o = a_i ^ b_i;
      OP_OR:     y_o = a_i | b_i;
      OP_AND:    y_o = a_i & b_i;
      default:   y_o = b_i;
    endcase
  end

  always_comb begin
    if (op_i == OP_SUB) begin
      assert_sub_wraps_R9: assert (XLEN'(y_o + b_i) == a_i)
        else $error("subtract result not modular");
    end
    if (op_i == OP_SLT || op_i == OP_SLTU) begin
      assert_cmp_is_bool_R6: assert (y_o[XLEN-1:1] == '0)
        else $error("compare result wider than one bit");
    end
  end

endmodule

// File: rtl/rvx_exec_unit.sv
module rvx_exec_unit
  import rvx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] result_o,
  output logic [4:0]      rd_o,
  output logic            wr_en_o,
  output logic            illegal_o
);

  alu_op_e         dec_op;
  logic            a_from_pc;
  logic            b_from_imm;
  logic [XLEN-1:0] dec_imm;
  logic [XLEN-1:0] opnd_a;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_y;

  rvx_decode #(.XLEN(XLEN)) u_decode (
    .instr_i      (instr_i),
    .op_o         (dec_op),
    .a_from_pc_o  (a_from_pc),
    .b_from_imm_o (b_from_imm),
    .imm_o        (dec_imm),
    .rd_o         (rd_o),
    .illegal_o    (illegal_o)
  );

  assign opnd_a = a_from_pc  ? pc_i    : rs1_val_i;
  assign opnd_b = b_from_imm ? dec_imm : rs2_val_i;

  rvx_alu #(.XLEN(XLEN)) u_alu (
    .op_i (dec_op),
    .a_i  (opnd_a),
    .b_i  (opnd_b),
    .y_o  (alu_y)
  );

  assign result_o = illegal_o ? '0 : alu_y;
  assign wr_en_o  = !illegal_o && (rd_o != 5'd0);

  always_comb begin
    if (illegal_o) begin
      assert_no_write_illegal_R11: assert (!wr_en_o)
        else $error("write strobe on illegal encoding");
    end
    if (rd_o == 5'd0) begin
      assert_x0_never_written_R10: assert (!wr_en_o)
        else $error("write strobe for register zero");
    end
    if (!illegal_o && rd_o != 5'd0) begin
      assert_legal_writes_R12: assert (wr_en_o)
        else $error("accepted instruction did not write");
    end
    if (!illegal_o && instr_i[6:0] == OPC_LUI) begin
      assert_lui_low_clear_R7: assert (result_o[11:0] == 12'h000)
        else $error("upper immediate low bits not clear");
    end
  end

endmodule

// File: tb/rvx_exec_unit_bench.sv
module rvx_exec_unit_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] rs1_val;
  logic [31:0] rs2_val;
  logic [31:0] pc;
  logic [31:0] result;
  logic [4:0]  rd;
  logic        wr_en;
  logic        illegal;

  int checks;
  int fails;
  int cycles;
  bit done;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  rd;
    logic        we;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  rvx_exec_unit u_rvx_exec_unit (
    .instr_i   (instr),
    .rs1_val_i (rs1_val),
    .rs2_val_i (rs2_val),
    .pc_i      (pc),
    .result_o  (result),
    .rd_o      (rd),
    .wr_en_o   (wr_en),
    .illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rdi);
    return {f7, rs2, rs1, f3, rdi, 7'b0110011};
  endfunction

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rdi);
    return {imm, rs1, f3, rdi, 7'b0010011};
  endfunction

  function automatic logic [31:0] enc_u(logic [19:0] imm, logic [4:0] rdi, logic [6:0] opc);
    return {imm, rdi, opc};
  endfunction

  task automatic drive(logic [31:0] ins, logic [31:0] a, logic [31:0] b, logic [31:0] p,
                       logic [31:0] e_res, logic [4:0] e_rd, logic e_we, logic e_ill,
                       string tag);
    exp_t item;
    @(posedge clk);
    #2;
    instr   = ins;
    rs1_val = a;
    rs2_val = b;
    pc      = p;
    item.res = e_res;
    item.rd  = e_rd;
    item.we  = e_we;
    item.ill = e_ill;
    item.tag = tag;
    sb_q.push_back(item);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (result !== e.res || rd !== e.rd || wr_en !== e.we || illegal !== e.ill) begin
        fails++;
        $display("FAIL %s: got res=%h rd=%0d we=%b ill=%b expected res=%h rd=%0d we=%b ill=%b",
                 e.tag, result, rd, wr_en, illegal, e.res, e.rd, e.we, e.ill);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements: cycles=%0d expected below 5000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n   = 1'b0;
    instr   = 32'h0;
    rs1_val = 32'h0;
    rs2_val = 32'h0;
    pc      = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset-time word of zero is an unknown opcode
    drive(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 1'b0, 1'b1, "R11 reset word zero");

    // register form, R1 R2 R12
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd5), 32'd5, 32'd7, 32'h0, 32'd12, 5'd5, 1'b1, 1'b0, "R2 add");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd6), 32'hFFFF_FFFF, 32'd2, 32'h0, 32'd1, 5'd6, 1'b1, 1'b0, "R9 add wrap");
    drive(enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd7), 32'd5, 32'd7, 32'h0, 32'hFFFF_FFFE, 5'd7, 1'b1, 1'b0, "R3 sub");
    drive(enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd8), 32'h8000_0000, 32'd1, 32'h0, 32'h7FFF_FFFF, 5'd8, 1'b1, 1'b0, "R9 sub wrap");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b100, 5'd9), 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h0, 32'hFF00_FF00, 5'd9, 1'b1, 1'b0, "R2 xor");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b110, 5'd10), 32'h1234_0000, 32'h0000_5678, 32'h0, 32'h1234_5678, 5'd10, 1'b1, 1'b0, "R2 or");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd11), 32'hFF00_FF00, 32'h0F0F_0F0F, 32'h0, 32'h0F00_0F00, 5'd11, 1'b1, 1'b0, "R2 and");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b001, 5'd12), 32'd1, 32'h0000_0024, 32'h0, 32'h10, 5'd12, 1'b1, 1'b0, "R5 sll low five bits");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b101, 5'd13), 32'h8000_0000, 32'd31, 32'h0, 32'd1, 5'd13, 1'b1, 1'b0, "R5 srl zero fill");
    drive(enc_r(7'h20, 5'd2, 5'd1, 3'b101, 5'd14), 32'h8000_0000, 32'd4, 32'h0, 32'hF800_0000, 5'd14, 1'b1, 1'b0, "R3 sra sign fill");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b101, 5'd14), 32'h8765_4321, 32'h0000_0020, 32'h0, 32'h8765_4321, 5'd14, 1'b1, 1'b0, "R5 srl by zero");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b010, 5'd15), 32'hFFFF_FFFF, 32'd1, 32'h0, 32'd1, 5'd15, 1'b1, 1'b0, "R6 slt signed");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b011, 5'd16), 32'hFFFF_FFFF, 32'd1, 32'h0, 32'd0, 5'd16, 1'b1, 1'b0, "R6 sltu unsigned");

    // immediate form, R4
    drive(enc_i(12'hFFF, 5'd1, 3'b000, 5'd17), 32'd10, 32'hDEAD_BEEF, 32'h0, 32'd9, 5'd17, 1'b1, 1'b0, "R4 addi negative");
    drive(enc_i(12'h400, 5'd1, 3'b000, 5'd17), 32'd1, 32'h0, 32'h0, 32'h401, 5'd17, 1'b1, 1'b0, "R4 addi bit30 still adds");
    drive(enc_i(12'h800, 5'd1, 3'b111, 5'd18), 32'h1234_5678, 32'h0, 32'h0, 32'h1234_5000, 5'd18, 1'b1, 1'b0, "R4 andi sign extended");
    drive(enc_i(12'hFFF, 5'd1, 3'b100, 5'd19), 32'h0000_000F, 32'h0, 32'h0, 32'hFFFF_FFF0, 5'd19, 1'b1, 1'b0, "R4 xori invert");
    drive(enc_i(12'h7FF, 5'd1, 3'b110, 5'd20), 32'h0, 32'h0, 32'h0, 32'h0000_07FF, 5'd20, 1'b1, 1'b0, "R4 ori positive");
    drive(enc_i(12'hFFF, 5'd1, 3'b010, 5'd21), 32'hFFFF_FFFE, 32'h0, 32'h0, 32'd1, 5'd21, 1'b1, 1'b0, "R6 slti signed");
    drive(enc_i(12'hFFF, 5'd1, 3'b011, 5'd22), 32'd5, 32'h0, 32'h0, 32'd1, 5'd22, 1'b1, 1'b0, "R6 sltiu extended imm");
    drive(enc_i(12'h001, 5'd1, 3'b011, 5'd22), 32'd0, 32'h0, 32'h0, 32'd1, 5'd22, 1'b1, 1'b0, "R6 sltiu zero test");
    drive(enc_i(12'h001, 5'd1, 3'b011, 5'd22), 32'd3, 32'h0, 32'h0, 32'd0, 5'd22, 1'b1, 1'b0, "R6 sltiu nonzero");
    drive(enc_i(12'h002, 5'd1, 3'b001, 5'd23), 32'd3, 32'hFFFF_FFFF, 32'h0, 32'd12, 5'd23, 1'b1, 1'b0, "R5 slli");
    drive(enc_i(12'h004, 5'd1, 3'b101, 5'd24), 32'hF000_0000, 32'h0, 32'h0, 32'h0F00_0000, 5'd24, 1'b1, 1'b0, "R5 srli");
    drive(enc_i(12'h404, 5'd1, 3'b101, 5'd25), 32'hF000_0000, 32'h0, 32'h0, 32'hFF00_0000, 5'd25, 1'b1, 1'b0, "R5 srai");

    // upper immediates, R1 R7 R8
    drive(enc_u(20'hABCDE, 5'd3, 7'b0110111), 32'h5555_5555, 32'h0, 32'h0, 32'hABCD_E000, 5'd3, 1'b1, 1'b0, "R7 lui ignores rs1");
    drive(enc_u(20'h00001, 5'd4, 7'b0010111), 32'h9999_9999, 32'h0, 32'h0000_1000, 32'h0000_2000, 5'd4, 1'b1, 1'b0, "R8 auipc");
    drive(enc_u(20'h00002, 5'd4, 7'b0010111), 32'h0, 32'h0, 32'hFFFF_F000, 32'h0000_1000, 5'd4, 1'b1, 1'b0, "R9 auipc wrap");

    // destination zero, R10
    drive(enc_i(12'h000, 5'd0, 3'b000, 5'd0), 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, "R10 nop");
    drive(enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd0), 32'd3, 32'd4, 32'h0, 32'd7, 5'd0, 1'b0, 1'b0, "R10 add to x0");

    // illegal encodings, R11
    drive(32'h0000_2083, 32'd1, 32'd2, 32'h0, 32'h0, 5'd1, 1'b0, 1'b1, "R11 load opcode");
    drive(enc_r(7'h01, 5'd2, 5'd1, 3'b000, 5'd5), 32'd3, 32'd4, 32'h0, 32'h0, 5'd5, 1'b0, 1'b1, "R11 funct7 0000001");
    drive(enc_r(7'h20, 5'd2, 5'd1, 3'b111, 5'd5), 32'd3, 32'd4, 32'h0, 32'h0, 5'd5, 1'b0, 1'b1, "R11 alt funct7 on and");
    drive(enc_i(12'h402, 5'd1, 3'b001, 5'd6), 32'd3, 32'd0, 32'h0, 32'h0, 5'd6, 1'b0, 1'b1, "R11 slli upper bits");
    drive(enc_i(12'h024, 5'd1, 3'b101, 5'd6), 32'd3, 32'd0, 32'h0, 32'h0, 5'd6, 1'b0, 1'b1, "R11 srli upper bits");
    drive({enc_i(12'h000, 5'd1, 3'b000, 5'd6)} & 32'hFFFF_FFFC, 32'd3, 32'd0, 32'h0, 32'h0, 5'd6, 1'b0, 1'b1, "R1 low opcode bits not 11");

    repeat (3) @(posedge clk);
    done = 1'b1;
    if (sb_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard all requirements: pending=%0d expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule